// File: doc/BRIEF.md
# Clear-to-Send Status and Transmit Flow Gate

This block handles the clear-to-send and request-to-send handshake lines of a serial port. The clear-to-send input arrives at the pin active low and asynchronous to the core clock. It passes through a flop chain synchroniser, is inverted, and is presented as a registered status bit. Any change of that bit, rising or falling, latches a delta flag. The flag stays set until software reads the status word, and it can raise an interrupt when the interrupt enable is set.

A loopback control replaces the pin with the request-to-send control bit, so software can exercise the handshake path without external wiring. When automatic clear-to-send flow control is on, the block withholds the transmit permit from the character engine while the status bit is low. A frame that is already being sent is never cut off. The request-to-send pin is driven either from the software control bit or, under automatic request-to-send control, from the receiver's readiness to accept data.

Top module: `cts_flow_ctl`

## Requirements
- R1: Outside loopback, `cts_state` equals the complement of `cts_n_pin`. A pin change made between two clock edges appears on `cts_state` at the third rising edge after it, because the pin passes two synchroniser flops and then the output register.
- R2: With `loopback_en` = 1, `cts_state` equals the `rts_ctrl` value sampled at the previous rising edge, and changes of `cts_n_pin` have no effect on `cts_state` or `cts_delta`.
- R3: Whenever `cts_state` changes, rising or falling, `cts_delta` is 1 after that same clock edge.
- R4: A one-cycle pulse on `status_rd` while `cts_delta` = 1, with no new change of state in that cycle, makes `cts_delta` 0 after the next rising edge.
- R5: If a change of state and a `status_rd` pulse fall on the same clock edge, `cts_delta` is 1 after that edge.
- R6: `irq` is 1 after a rising edge exactly when `irq_en` was 1 at that edge and `cts_delta` is 1 after it. With `irq_en` = 0, `irq` stays 0.
- R7: `tx_permit` is 1 when `auto_cts_en` = 0, when `cts_state` = 1, or when `tx_busy` = 1. It is 0 otherwise. It updates on the same edge as `cts_state`, using the control inputs sampled at that edge.
- R8: One edge after its inputs are sampled, `rts_n_pin` equals NOT `rx_ready` when `auto_rts_en` = 1, and NOT `rts_ctrl` when `auto_rts_en` = 0.
- R9: While `rst` is high and after it, with the pin held high, the outputs are `cts_state` = 0, `cts_delta` = 0, `irq` = 0, `tx_permit` = 1 and `rts_n_pin` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| cts_n_pin | input | 1 | Raw clear-to-send pin, active low, asynchronous |
| loopback_en | input | 1 | Use the RTS control bit as the CTS source |
| rts_ctrl | input | 1 | Software request-to-send control bit |
| auto_cts_en | input | 1 | Enable automatic CTS gating of transmit start |
| auto_rts_en | input | 1 | Drive RTS from receiver readiness |
| irq_en | input | 1 | Modem status interrupt enable |
| status_rd | input | 1 | One-cycle strobe: status word is being read |
| tx_busy | input | 1 | Transmitter is in the middle of a frame |
| rx_ready | input | 1 | Receiver can accept more data |
| cts_state | output | 1 | Clear-to-send status, active high |
| cts_delta | output | 1 | Sticky change flag for cts_state |
| irq | output | 1 | Modem status interrupt |
| tx_permit | output | 1 | Transmitter may start a new frame |
| rts_n_pin | output | 1 | Request-to-send pin, active low |

## Verification
The hardest case to reach from the ports is a change of state and a status read that fall on the same clock edge. Through the pin, the edge where the change is captured sits three cycles behind the stimulus, so hitting it exactly would depend on counting synchroniser stages. The bench therefore enters loopback, where the change is captured one edge after `rts_ctrl` moves. It flips `rts_ctrl` and pulses `status_rd` in the same cycle. The permit and RTS pin behaviour is swept over every combination of their three inputs.

// File: rtl/cts_flow_pkg.sv
`timescale 1ns/1ps
package cts_flow_pkg;
  // idle level of the active-low handshake pins
  localparam logic PIN_IDLE = 1'b1;

  // transmit may start unless auto gating is on, CTS is low and no frame runs
  function automatic logic permit_f(input logic auto_en, input logic cts, input logic busy);
    return !auto_en || cts || busy;
  endfunction

  // RTS pin level (active low) from the selected request source
  function automatic logic rts_pin_f(input logic auto_en, input logic rx_rdy, input logic ctrl);
    return auto_en ? !rx_rdy : !ctrl;
  endfunction
endpackage

// File: rtl/cts_sync.sv
`timescale 1ns/1ps
module cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  import cts_flow_pkg::*;

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= PIN_IDLE;
        else     chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{PIN_IDLE}};
        else     chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cts_delta.sv
`timescale 1ns/1ps
module cts_delta (
  input  logic clk,
  input  logic rst,
  input  logic sync_n,
  input  logic loopback_en,
  input  logic rts_ctrl,
  input  logic status_rd,
  input  logic irq_en,
  output logic level_nxt,
  output logic cts_state,
  output logic cts_delta,
  output logic irq
);
  logic change;
  logic delta_nxt;

  always_comb begin
    level_nxt = loopback_en ? rts_ctrl : !sync_n;
    change    = level_nxt != cts_state;
    // a change captured on the read edge wins over the clear
    delta_nxt = change || (cts_delta && !status_rd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cts_state <= 1'b0;
      cts_delta <= 1'b0;
      irq       <= 1'b0;
    end else begin
      cts_state <= level_nxt;
      cts_delta <= delta_nxt;
      irq       <= irq_en && delta_nxt;
    end
  end
endmodule

// File: rtl/cts_gate.sv
`timescale 1ns/1ps
module cts_gate (
  input  logic clk,
  input  logic rst,
  input  logic level_nxt,
  input  logic auto_cts_en,
  input  logic tx_busy,
  input  logic auto_rts_en,
  input  logic rx_ready,
  input  logic rts_ctrl,
  output logic tx_permit,
  output logic rts_n_pin
);
  import cts_flow_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_permit <= 1'b1;
      rts_n_pin <= PIN_IDLE;
    end else begin
      tx_permit <= permit_f(auto_cts_en, level_nxt, tx_busy);
      rts_n_pin <= rts_pin_f(auto_rts_en, rx_ready, rts_ctrl);
    end
  end
endmodule

// File: rtl/cts_flow_ctl.sv
`timescale 1ns/1ps
module cts_flow_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_n_pin,
  input  logic loopback_en,
  input  logic rts_ctrl,
  input  logic auto_cts_en,
  input  logic auto_rts_en,
  input  logic irq_en,
  input  logic status_rd,
  input  logic tx_busy,
  input  logic rx_ready,
  output logic cts_state,
  output logic cts_delta,
  output logic irq,
  output logic tx_permit,
  output logic rts_n_pin
);
  logic sync_n;
  logic level_nxt;

  cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (cts_n_pin),
    .q_sync  (sync_n)
  );

  cts_delta u_delta (
    .clk         (clk),
    .rst         (rst),
    .sync_n      (sync_n),
    .loopback_en (loopback_en),
    .rts_ctrl    (rts_ctrl),
    .status_rd   (status_rd),
    .irq_en      (irq_en),
    .level_nxt   (level_nxt),
    .cts_state   (cts_state),
    .cts_delta   (cts_delta),
    .irq         (irq)
  );

  cts_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .level_nxt   (level_nxt),
    .auto_cts_en (auto_cts_en),
    .tx_busy     (tx_busy),
    .auto_rts_en (auto_rts_en),
    .rx_ready    (rx_ready),
    .rts_ctrl    (rts_ctrl),
    .tx_permit   (tx_permit),
    .rts_n_pin   (rts_n_pin)
  );
endmodule

// File: rtl/cts_flow_chk.sv
`timescale 1ns/1ps
module cts_flow_chk (
  input logic clk,
  input logic rst,
  input logic sync_n,
  input logic loopback_en,
  input logic rts_ctrl,
  input logic auto_cts_en,
  input logic auto_rts_en,
  input logic irq_en,
  input logic status_rd,
  input logic tx_busy,
  input logic rx_ready,
  input logic cts_state,
  input logic cts_delta,
  input logic irq,
  input logic tx_permit,
  input logic rts_n_pin
);
  a_r1_pin_inverted: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(loopback_en)) |-> (cts_state == !$past(sync_n)));

  a_r2_loopback_src: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(loopback_en)) |-> (cts_state == $past(rts_ctrl)));

  a_r3_change_flags: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (cts_state != $past(cts_state))) |-> cts_delta);

  a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(status_rd) && $stable(cts_state)) |-> !cts_delta);

  a_r6_irq_gated: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && irq) |-> ($past(irq_en) && cts_delta));

  a_r7_permit_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(auto_cts_en) && !$past(tx_busy) && !cts_state) |-> !tx_permit);

  a_r8_rts_pin: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(auto_rts_en)) |-> (rts_n_pin == !$past(rts_ctrl)));
endmodule

bind cts_flow_ctl cts_flow_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .sync_n      (sync_n),
  .loopback_en (loopback_en),
  .rts_ctrl    (rts_ctrl),
  .auto_cts_en (auto_cts_en),
  .auto_rts_en (auto_rts_en),
  .irq_en      (irq_en),
  .status_rd   (status_rd),
  .tx_busy     (tx_busy),
  .rx_ready    (rx_ready),
  .cts_state   (cts_state),
  .cts_delta   (cts_delta),
  .irq         (irq),
  .tx_permit   (tx_permit),
  .rts_n_pin   (rts_n_pin)
);

// File: tb/sim_cts_flow_ctl.sv
`timescale 1ns/1ps
module sim_cts_flow_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cts_n_pin = 1'b1;
  logic loopback_en = 1'b0;
  logic rts_ctrl = 1'b0;
  logic auto_cts_en = 1'b0;
  logic auto_rts_en = 1'b0;
  logic irq_en = 1'b0;
  logic status_rd = 1'b0;
  logic tx_busy = 1'b0;
  logic rx_ready = 1'b0;
  logic cts_state, cts_delta, irq, tx_permit, rts_n_pin;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  cts_flow_ctl u0 (
    .clk(clk), .rst(rst), .cts_n_pin(cts_n_pin), .loopback_en(loopback_en),
    .rts_ctrl(rts_ctrl), .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en),
    .irq_en(irq_en), .status_rd(status_rd), .tx_busy(tx_busy), .rx_ready(rx_ready),
    .cts_state(cts_state), .cts_delta(cts_delta), .irq(irq),
    .tx_permit(tx_permit), .rts_n_pin(rts_n_pin)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_delta();
    status_rd = 1'b1;
    tick(1);
    status_rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    // R9 reset state
    chk("R9 cts_state", cts_state, 1'b0);
    chk("R9 cts_delta", cts_delta, 1'b0);
    chk("R9 irq", irq, 1'b0);
    chk("R9 tx_permit", tx_permit, 1'b1);
    chk("R9 rts_n_pin", rts_n_pin, 1'b1);
    rst = 1'b0;
    tick(4);
    chk("R9 idle after reset", cts_delta, 1'b0);

    // R1/R3/R4/R6: pin sweeps, interrupt off then on
    for (int en = 0; en < 2; en++) begin
      irq_en = en[0];
      for (int k = 0; k < 4; k++) begin
        logic p;
        p = k[0];
        cts_n_pin = p;
        tick(2);
        chk("R1 latency not yet", cts_state, cts_n_pin ? 1'b1 : 1'b0);
        tick(1);
        chk("R1 level", cts_state, !p);
        chk("R3 delta set", cts_delta, 1'b1);
        chk("R6 irq", irq, en[0]);
        clear_delta();
        chk("R4 delta cleared", cts_delta, 1'b0);
        chk("R6 irq drops", irq, 1'b0);
      end
    end
    irq_en = 1'b0;

    // R2: loopback follows rts_ctrl, pin ignored
    cts_n_pin = 1'b1;
    tick(4);
    loopback_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      rts_ctrl = ~k[0];
      tick(1);
      chk("R2 loopback level", cts_state, ~k[0]);
      clear_delta();
      cts_n_pin = ~cts_n_pin;
      tick(4);
      chk("R2 pin ignored state", cts_state, ~k[0]);
      chk("R2 pin ignored delta", cts_delta, 1'b0);
    end

    // R5: change and read on the same edge
    for (int k = 0; k < 2; k++) begin
      clear_delta();
      rts_ctrl = ~rts_ctrl;
      status_rd = 1'b1;
      tick(1);
      status_rd = 1'b0;
      chk("R5 change kept on read", cts_delta, 1'b1);
      chk("R5 state moved", cts_state, rts_ctrl);
    end
    clear_delta();

    // R7: permit sweep over auto_cts, cts level, busy
    for (int v = 0; v < 8; v++) begin
      auto_cts_en = v[2];
      rts_ctrl = v[1];
      tx_busy = v[0];
      tick(1);
      chk("R7 tx_permit", tx_permit, !v[2] || v[1] || v[0]);
    end
    auto_cts_en = 1'b0;
    tx_busy = 1'b0;

    // R8: RTS pin sweep
    for (int v = 0; v < 8; v++) begin
      auto_rts_en = v[2];
      rx_ready = v[1];
      rts_ctrl = v[0];
      tick(1);
      chk("R8 rts_n_pin", rts_n_pin, v[2] ? !v[1] : !v[0]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule